// File: doc/BRIEF.md
# Serial presence detect validator

This block qualifies a memory module before a memory controller programs its timing. After a start pulse it fetches the first 64 bytes of the module's configuration EEPROM one at a time. Each byte is fetched through a simple request/acknowledge port that an external two-wire bus engine serves. The device address sent with every request is the fixed prefix `1010` followed by the three slot strap bits.

While the bytes stream in, the block keeps a running 8-bit sum of bytes 0 to 62 and captures the bytes that describe the module's geometry and timing. When byte 63, the stored checksum, arrives, it checks the checksum, the memory type and the CAS latency support. It then reports one verdict and the decoded parameters.

The packed cycle-time bytes are turned into picoseconds. The whole-nanosecond delay bytes are turned into controller clock counts, rounded up, for a controller clock period given as a parameter. The block also picks the lowest CAS latency that the module supports at that clock period. If the bus engine stops answering, a timeout ends the fetch with an error.

Top module: `spd_checker`

## Requirements
- R1: After reset, rd_req, busy, done, valid and err are all 0.
- R2: The cycle after start is sampled while idle, rd_req goes high with rd_off = 0. Each acknowledged byte moves rd_off to the next offset in the following cycle, up to 63. rd_off holds while no ack arrives. rd_dev always equals {4'b1010, strap}.
- R3: A start pulse that arrives while busy is ignored: the running fetch continues at its current offset.
- R4: done pulses for one cycle, the cycle after the ack for offset 63. At that point exactly one of valid and err is 1, and both hold until the next accepted start, which clears them.
- R5: The checksum test fails when the low 8 bits of the sum of bytes 0..62 differ from byte 63. The result is err = 1 with err_code = 1.
- R6: The memory type test fails when byte 2 is not 0x04. The result is err = 1 with err_code = 2, unless R5 also fails; R5 takes priority.
- R7: The CAS support test fails when byte 18 has neither bit 1 (CAS latency 2) nor bit 2 (CAS latency 3) set. The result is err_code = 3. It has the lowest priority, behind R5 and R6.
- R8: If rd_req stays high for TMO_CYC consecutive cycles without an ack, the fetch ends: rd_req falls, and done pulses with err = 1 and err_code = 0.
- R9: Once valid, row_bits = byte 3 [4:0], col_bits = byte 4 [4:0], bank_cnt = byte 17, bl_mask = byte 16 [3:0] and cas_mask = byte 18.
- R10: Once valid, tck3_ps decodes byte 9 and tck2_ps decodes byte 23, each as upper nibble × 1000 + lower nibble × 100.
- R11: Once valid, trp_ck, trrd_ck, trcd_ck and tras_ck equal ceil(ns × 1000 / CLK_PS), where ns is byte 27, 28, 29 and 30 respectively.
- R12: Once valid, cas_sel is 2 if CAS latency 2 is supported and tck2_ps ≤ CLK_PS. Otherwise it is 3 if CAS latency 3 is supported and tck3_ps ≤ CLK_PS. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that starts a fetch |
| strap | input | 3 | Slot address straps |
| rd_req | output | 1 | Byte read request, held until ack |
| rd_dev | output | 7 | Bus device address for the request |
| rd_off | output | 8 | Byte offset requested |
| rd_ack | input | 1 | One-cycle acknowledge, qualifies rd_data |
| rd_data | input | 8 | Byte returned with rd_ack |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle end-of-fetch pulse |
| valid | output | 1 | Module accepted |
| err | output | 1 | Module rejected or fetch timed out |
| err_code | output | 2 | 0 timeout, 1 checksum, 2 type, 3 no CAS 2/3 |
| row_bits | output | 5 | Row address bits |
| col_bits | output | 5 | Column address bits |
| bank_cnt | output | 8 | Internal bank count |
| bl_mask | output | 4 | Supported burst length mask |
| cas_mask | output | 8 | Supported CAS latency mask |
| tck3_ps | output | 16 | Minimum cycle time at CAS 3, ps |
| tck2_ps | output | 16 | Minimum cycle time at CAS 2, ps |
| cas_sel | output | 2 | Chosen CAS latency, 0 if none fits |
| trp_ck | output | 8 | Precharge time in clocks |
| trrd_ck | output | 8 | Bank-to-bank delay in clocks |
| trcd_ck | output | 8 | Row-to-column delay in clocks |
| tras_ck | output | 8 | Active period in clocks |

## Verification
Each result has a fixed due cycle. rd_req and offset 0 appear one cycle after start. The next offset appears one cycle after each ack. done, the verdict and cas_sel appear one cycle after the ack for offset 63. A silent bus engine produces the timeout pulse after exactly TMO_CYC cycles of request. The bench's behavioural model advances on the same rising edge as the design, and every output is compared on the following falling edge. Each result is therefore checked in the cycle it is due and in no other. Decoded fields are compared on the done cycle of every accepted module. The stimulus covers several EEPROM images, bus latencies, strap values, a mid-fetch start, each rejection cause, combined causes and a timeout.

// File: rtl/spd_checker.sv
module spd_checker #(
  parameter int unsigned CLK_PS  = 7500,
  parameter int unsigned TMO_CYC = 64,
  parameter int unsigned CK_W    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      strap,
  output logic            rd_req,
  output logic [6:0]      rd_dev,
  output logic [7:0]      rd_off,
  input  logic            rd_ack,
  input  logic [7:0]      rd_data,
  output logic            busy,
  output logic            done,
  output logic            valid,
  output logic            err,
  output logic [1:0]      err_code,
  output logic [4:0]      row_bits,
  output logic [4:0]      col_bits,
  output logic [7:0]      bank_cnt,
  output logic [3:0]      bl_mask,
  output logic [7:0]      cas_mask,
  output logic [15:0]     tck3_ps,
  output logic [15:0]     tck2_ps,
  output logic [1:0]      cas_sel,
  output logic [CK_W-1:0] trp_ck,
  output logic [CK_W-1:0] trrd_ck,
  output logic [CK_W-1:0] trcd_ck,
  output logic [CK_W-1:0] tras_ck
);

  localparam int unsigned TW = $clog2(TMO_CYC + 1);

  logic          run;
  logic [5:0]    idx;
  logic [TW-1:0] wcnt;
  logic [7:0]    sum;
  logic [7:0]    type_b;

  function automatic logic [15:0] tck_ps(input logic [7:0] b);
    return 16'(b[7:4]) * 16'd1000 + 16'(b[3:0]) * 16'd100;
  endfunction

  function automatic logic [CK_W-1:0] ns_to_ck(input logic [7:0] ns);
    logic [31:0] t;
    t = (32'(ns) * 32'd1000 + CLK_PS - 32'd1) / CLK_PS;
    return t[CK_W-1:0];
  endfunction

  assign rd_req = run;
  assign busy   = run;
  assign rd_off = {2'b00, idx};
  assign rd_dev = {4'b1010, strap};

  wire last   = (idx == 6'd63);
  wire tmo    = run & ~rd_ack & (wcnt == TW'(TMO_CYC - 1));
  wire cs_bad = (sum != rd_data);
  wire ty_bad = (type_b != 8'h04);
  wire cl_bad = ~cas_mask[1] & ~cas_mask[2];
  wire ok     = ~cs_bad & ~ty_bad & ~cl_bad;

  logic [1:0] code;
  always_comb begin
    if (cs_bad)      code = 2'd1;
    else if (ty_bad) code = 2'd2;
    else if (cl_bad) code = 2'd3;
    else             code = 2'd0;
  end

  wire fit2 = cas_mask[1] & (32'(tck2_ps) <= CLK_PS);
  wire fit3 = cas_mask[2] & (32'(tck3_ps) <= CLK_PS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      idx      <= '0;
      wcnt     <= '0;
      sum      <= '0;
      done     <= 1'b0;
      valid    <= 1'b0;
      err      <= 1'b0;
      err_code <= '0;
      cas_sel  <= '0;
    end else begin
      done <= 1'b0;
      if (!run) begin
        if (start) begin
          run   <= 1'b1;
          idx   <= '0;
          wcnt  <= '0;
          sum   <= '0;
          valid <= 1'b0;
          err   <= 1'b0;
        end
      end else if (rd_ack) begin
        wcnt <= '0;
        if (last) begin
          run      <= 1'b0;
          done     <= 1'b1;
          valid    <= ok;
          err      <= ~ok;
          err_code <= code;
          cas_sel  <= fit2 ? 2'd2 : (fit3 ? 2'd3 : 2'd0);
        end else begin
          idx <= idx + 6'd1;
          sum <= sum + rd_data;
        end
      end else if (tmo) begin
        run      <= 1'b0;
        done     <= 1'b1;
        err      <= 1'b1;
        err_code <= 2'd0;
      end else begin
        wcnt <= wcnt + TW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      type_b   <= '0;
      row_bits <= '0;
      col_bits <= '0;
      bank_cnt <= '0;
      bl_mask  <= '0;
      cas_mask <= '0;
      tck3_ps  <= '0;
      tck2_ps  <= '0;
      trp_ck   <= '0;
      trrd_ck  <= '0;
      trcd_ck  <= '0;
      tras_ck  <= '0;
    end else if (run && rd_ack) begin
      case (idx)
        6'd2:  type_b   <= rd_data;
        6'd3:  row_bits <= rd_data[4:0];
        6'd4:  col_bits <= rd_data[4:0];
        6'd9:  tck3_ps  <= tck_ps(rd_data);
        6'd16: bl_mask  <= rd_data[3:0];
        6'd17: bank_cnt <= rd_data;
        6'd18: cas_mask <= rd_data;
        6'd23: tck2_ps  <= tck_ps(rd_data);
        6'd27: trp_ck   <= ns_to_ck(rd_data);
        6'd28: trrd_ck  <= ns_to_ck(rd_data);
        6'd29: trcd_ck  <= ns_to_ck(rd_data);
        6'd30: tras_ck  <= ns_to_ck(rd_data);
        default: ;
      endcase
    end
  end

  a_r2_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (!rd_req || $stable(rd_off)));

  a_r2_step_off: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_ack && rd_off != 8'd63) |=> (rd_req && rd_off == $past(rd_off) + 8'd1));

  a_r4_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_ack && rd_off == 8'd63) |=> (done && !rd_req));

  a_r4_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (valid != err));

  a_r8_timeout_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err && err_code == 2'd0) |-> ($past(rd_req) && !$past(rd_ack)));

endmodule

// File: tb/spd_checker_tb.sv
module spd_checker_tb;
  localparam int CLK_PS = 7500;
  localparam int TMO    = 64;

  logic clk = 0, rst_n = 0, start = 0, rd_ack = 0;
  logic [2:0] strap = 3'b010;
  logic [7:0] rd_data = 0;
  logic rd_req, busy, done, valid, err;
  logic [6:0] rd_dev;
  logic [7:0] rd_off, bank_cnt, cas_mask, trp_ck, trrd_ck, trcd_ck, tras_ck;
  logic [1:0] err_code, cas_sel;
  logic [4:0] row_bits, col_bits;
  logic [3:0] bl_mask;
  logic [15:0] tck3_ps, tck2_ps;

  always #2.5 clk = ~clk;

  spd_checker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .strap(strap),
    .rd_req(rd_req), .rd_dev(rd_dev), .rd_off(rd_off), .rd_ack(rd_ack), .rd_data(rd_data),
    .busy(busy), .done(done), .valid(valid), .err(err), .err_code(err_code),
    .row_bits(row_bits), .col_bits(col_bits), .bank_cnt(bank_cnt), .bl_mask(bl_mask),
    .cas_mask(cas_mask), .tck3_ps(tck3_ps), .tck2_ps(tck2_ps), .cas_sel(cas_sel),
    .trp_ck(trp_ck), .trrd_ck(trrd_ck), .trcd_ck(trcd_ck), .tras_ck(tras_ck));

  int total = 0, bad = 0;
  int img [64];
  int resp_lat = 0;
  bit silent = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int dec_tck(input int b);
    return (b / 16) * 1000 + (b % 16) * 100;
  endfunction

  function automatic int to_ck(input int ns);
    int c;
    c = 0;
    while (c * CLK_PS < ns * 1000) c++;
    return c;
  endfunction

  // behavioural reference model
  bit m_busy = 0, m_done = 0, m_valid = 0, m_err = 0;
  int m_idx = 0, m_wait = 0, m_sum = 0, m_code = 0;
  int m_b [64];

  always @(posedge clk) begin
    m_done = 0;
    if (!rst_n) begin
      m_busy = 0; m_valid = 0; m_err = 0; m_idx = 0; m_wait = 0;
    end else if (!m_busy) begin
      if (start) begin
        m_busy = 1; m_idx = 0; m_wait = 0; m_sum = 0; m_valid = 0; m_err = 0;
      end
    end else if (rd_ack) begin
      m_b[m_idx] = rd_data;
      m_wait = 0;
      if (m_idx == 63) begin
        m_busy = 0; m_done = 1;
        if ((m_sum % 256) != rd_data) m_code = 1;
        else if (m_b[2] != 4)          m_code = 2;
        else if ((m_b[18] & 6) == 0)   m_code = 3;
        else                           m_code = -1;
        m_valid = (m_code < 0);
        m_err = !m_valid;
      end else begin
        m_sum += rd_data;
        m_idx++;
      end
    end else if (m_wait == TMO - 1) begin
      m_busy = 0; m_done = 1; m_err = 1; m_valid = 0; m_code = 0;
    end else begin
      m_wait++;
    end
  end

  function automatic int exp_cas();
    if ((m_b[18] & 2) != 0 && dec_tck(m_b[23]) <= CLK_PS) return 2;
    if ((m_b[18] & 4) != 0 && dec_tck(m_b[9]) <= CLK_PS) return 3;
    return 0;
  endfunction

  // per-cycle comparison on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        chk("R2 rd_req", rd_req, m_busy);
        chk("R2 rd_dev", rd_dev, 'h50 + strap);
        if (m_busy) chk("R2 rd_off", rd_off, m_idx);
        chk("R4 done", done, m_done);
        chk("R4 valid", valid, m_valid);
        chk("R4 err", err, m_err);
        if (m_done && m_err) begin
          case (m_code)
            0: chk("R8 err_code", err_code, 0);
            1: chk("R5 err_code", err_code, 1);
            2: chk("R6 err_code", err_code, 2);
            default: chk("R7 err_code", err_code, 3);
          endcase
        end
        if (m_done && m_valid) begin
          chk("R9 row_bits", row_bits, m_b[3] % 32);
          chk("R9 col_bits", col_bits, m_b[4] % 32);
          chk("R9 bank_cnt", bank_cnt, m_b[17]);
          chk("R9 bl_mask", bl_mask, m_b[16] % 16);
          chk("R9 cas_mask", cas_mask, m_b[18]);
          chk("R10 tck3_ps", tck3_ps, dec_tck(m_b[9]));
          chk("R10 tck2_ps", tck2_ps, dec_tck(m_b[23]));
          chk("R11 trp_ck", trp_ck, to_ck(m_b[27]));
          chk("R11 trrd_ck", trrd_ck, to_ck(m_b[28]));
          chk("R11 trcd_ck", trcd_ck, to_ck(m_b[29]));
          chk("R11 tras_ck", tras_ck, to_ck(m_b[30]));
          chk("R12 cas_sel", cas_sel, exp_cas());
        end
      end
    end
  end

  // EEPROM responder
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (rd_ack) begin
        rd_ack = 0; cnt = 0;
      end else if (rd_req && !silent) begin
        if (cnt >= resp_lat) begin
          rd_ack = 1; rd_data = 8'(img[rd_off[5:0]]);
        end else cnt++;
      end else cnt = 0;
    end
  end

  task automatic make_img(input int ty, input int cl, input int t9, input int t23,
                          input int trp, input bit corrupt);
    int s;
    for (int i = 0; i < 64; i++) img[i] = (i * 37 + 5) % 256;
    img[0] = 'h80; img[1] = 'h08; img[2] = ty; img[3] = 12; img[4] = 10;
    img[9] = t9; img[16] = 'h0F; img[17] = 4; img[18] = cl; img[23] = t23;
    img[27] = trp; img[28] = 'h0F; img[29] = 'h14; img[30] = 'h2D;
    s = 0;
    for (int i = 0; i < 63; i++) s += img[i];
    img[63] = (s + (corrupt ? 1 : 0)) % 256;
  endtask

  task automatic run_fetch(input int mid_start);
    int n;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk); n++;
      if (n == mid_start) start = 1;   // R3: start while busy
      else start = 0;
    end
    start = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rd_req", rd_req, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 valid", valid, 0);
    chk("R1 err", err, 0);
    rst_n = 1;
    @(negedge clk);

    make_img('h04, 'h06, 'h75, 'hA0, 'h14, 0); resp_lat = 0; run_fetch(0);
    strap = 3'b101;
    make_img('h04, 'h06, 'h70, 'h75, 'h0F, 0); resp_lat = 3; run_fetch(40);   // R3
    make_img('h04, 'h04, 'h80, 'hA0, 'h28, 0); resp_lat = 1; run_fetch(0);   // R12 none fits
    make_img('h04, 'h02, 'h75, 'h75, 'h14, 0); resp_lat = 0; run_fetch(0);   // R12 CL2 only
    make_img('h04, 'h06, 'h75, 'hA0, 'h14, 1); resp_lat = 2; run_fetch(0);   // R5
    make_img('h02, 'h06, 'h75, 'hA0, 'h14, 0); resp_lat = 0; run_fetch(0);   // R6
    make_img('h02, 'h01, 'h75, 'hA0, 'h14, 1); resp_lat = 0; run_fetch(0);   // R5 over R6/R7
    make_img('h04, 'h01, 'h75, 'hA0, 'h14, 0); resp_lat = 0; run_fetch(0);   // R7
    make_img('h02, 'h00, 'h75, 'hA0, 'h14, 0); resp_lat = 0; run_fetch(0);   // R6 over R7
    silent = 1; strap = 3'b000; run_fetch(0);                                // R8
    chk("R8 rd_req low after timeout", rd_req, 0);
    silent = 0;
    make_img('h04, 'h06, 'h75, 'hA0, 'h14, 0); resp_lat = 5; run_fetch(0);
    chk("R4 valid held", valid, 1);
    chk("R4 err held", err, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule